// File: doc/BRIEF.md
# Address comparator value bank

This block holds a bank of programmable 64-bit address values, one per address comparator, and compares each trace address sample against every stored value. A register port loads and reads the values by index. A stream of address samples arrives over a valid/ready interface. Each sample carries a flag that marks it as a 32-bit (narrow) or 64-bit address. For each accepted sample the block delivers one per-comparator match vector on a valid/ready output stream.

The number of comparators is twice the parameter `NUM_PAIRS`, which runs from 1 to 8, so up to 16 comparators exist with indices 0 to 15. `VA_BITS` (P, from 32 to 64) is the implemented virtual address width. Writes clean up bits [63:P] so that the stored value is always predictable. Writes are only allowed while the trace unit reports idle. Accesses to indices that are not implemented are flagged as undefined.

Back-pressure on the streams works as follows. The output register holds one result. `s_ready` is high whenever that register is empty or is being drained in the same cycle (`m_ready` high). While `m_valid` is high and `m_ready` is low, the result is held unchanged and no new sample is accepted.

Top module: `acv_bank`

## Requirements
- R1: Only indices below 2*NUM_PAIRS are implemented. A write to any other index stores nothing and raises `wr_undef` for exactly one cycle, in the cycle after the write. A read of such an index returns zero with `rd_undef` high.
- R2: A write to an implemented index while `trace_idle` is high stores the value. `rd_data` for that index shows the value from the cycle after the write.
- R3: A written value whose bits [63:VA_BITS] are all zeros or all ones is stored and read back exactly as written.
- R4: A written value whose bits [63:VA_BITS] are mixed is stored with those bits replaced by copies of bit VA_BITS-1. The bits below VA_BITS are kept.
- R5: A write to an implemented index while `trace_idle` is low changes no stored value and raises `wr_busy` for exactly one cycle, in the cycle after the write.
- R6: When `s_narrow` is 1, the sample's bits [31:0] are zero-extended to 64 bits before the compare. The compare then covers all 64 stored bits, so a stored value with any of bits [63:32] set never matches a narrow sample.
- R7: For an accepted sample, bit i of `m_match` is 1 when comparator i is implemented and its stored value equals the extended address. The result appears with `m_valid` in the cycle after acceptance. Bits for unimplemented comparators are always 0.
- R8: A sample accepted while `enable` is low still produces a result, and its match vector is all zeros.
- R9: `s_ready` is high exactly when `m_valid` is low or `m_ready` is high. While `m_valid` is high and `m_ready` is low, `m_valid` and `m_match` hold their values.
- R10: After reset all stored values are zero, `m_valid` is low, and `wr_undef` and `wr_busy` are low.
- R11: A sample accepted in the same cycle as a write is compared against the values stored before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Match enable, sampled when a sample is accepted |
| trace_idle | input | 1 | High while the trace unit is idle; writes are allowed only then |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Comparator index to write |
| wr_data | input | 64 | Value to write |
| wr_undef | output | 1 | One-cycle pulse: previous write targeted an unimplemented index |
| wr_busy | output | 1 | One-cycle pulse: previous write was refused because the trace unit was not idle |
| rd_idx | input | 4 | Comparator index to read |
| rd_data | output | 64 | Stored value at rd_idx (combinational); zero if unimplemented |
| rd_undef | output | 1 | rd_idx is not implemented |
| s_valid | input | 1 | Address sample valid |
| s_ready | output | 1 | Block can accept a sample |
| s_addr | input | 64 | Address sample |
| s_narrow | input | 1 | 1: sample is a 32-bit address in bits [31:0] |
| m_valid | output | 1 | Match result valid |
| m_ready | input | 1 | Consumer takes the result |
| m_match | output | 16 | Per-comparator match vector |

## Verification
The assertions assume that `s_valid`, `s_addr` and the write inputs are at known levels after reset, and that `VA_BITS` is between 32 and 64. The hold-stability checks only rely on the block's own output register, so they make no assumption about whether the producer keeps `s_valid` high. The bench drives random samples, narrow flags, back-pressure and writes (some while busy, some to unimplemented indices). It takes addresses both from the values it has stored and from random patterns, so matches and misses both occur under every handshake combination.

// File: rtl/acv_pkg.sv
package acv_pkg;
  localparam int ACV_SLOTS  = 16;
  localparam int ACV_IDX_W  = 4;
  localparam int ACV_DATA_W = 64;
  localparam int ACV_NARROW_W = 32;
  typedef logic [ACV_DATA_W-1:0] acv_word_t;
  typedef logic [ACV_SLOTS-1:0]  acv_vec_t;
endpackage

// File: rtl/acv_wr_sanitize.sv
module acv_wr_sanitize
  import acv_pkg::*;
#(
  parameter int VA_BITS = 48
) (
  input  acv_word_t din,
  output acv_word_t dout
);
  generate
    if (VA_BITS >= ACV_DATA_W) begin : g_full
      assign dout = din;
    end else begin : g_trim
      localparam int HI_W = ACV_DATA_W - VA_BITS;
      logic [HI_W-1:0] upper;
      logic            uniform;
      assign upper   = din[ACV_DATA_W-1:VA_BITS];
      assign uniform = (~|upper) | (&upper);
      assign dout    = uniform ? din
                               : {{HI_W{din[VA_BITS-1]}}, din[VA_BITS-1:0]};
    end
  endgenerate
endmodule

// File: rtl/acv_value_bank.sv
module acv_value_bank
  import acv_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int VA_BITS   = 48,
  localparam int NUM_CMP  = 2 * NUM_PAIRS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trace_idle,
  input  logic                     wr_en,
  input  logic [ACV_IDX_W-1:0]     wr_idx,
  input  acv_word_t                wr_data,
  output logic                     wr_undef,
  output logic                     wr_busy,
  input  logic [ACV_IDX_W-1:0]     rd_idx,
  output acv_word_t                rd_data,
  output logic                     rd_undef,
  output logic [NUM_CMP-1:0][ACV_DATA_W-1:0] vals
);
  acv_word_t clean;
  logic      wr_impl;
  logic      wr_ok;

  acv_wr_sanitize #(.VA_BITS(VA_BITS)) u_san (.din(wr_data), .dout(clean));

  assign wr_impl = ({1'b0, wr_idx} < (ACV_IDX_W+1)'(NUM_CMP));
  assign wr_ok   = wr_en & wr_impl & trace_idle;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CMP; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          vals[gi] <= '0;
        else if (wr_ok && (wr_idx == ACV_IDX_W'(gi)))
          vals[gi] <= clean;
      end

      // R5: a refused write leaves every slot untouched
      a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !trace_idle) |=> $stable(vals[gi]));

      // R1: a write to an unimplemented index stores nothing
      a_r1_undef_nostore: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_impl) |=> $stable(vals[gi]));

      if (VA_BITS < ACV_DATA_W) begin : g_up_chk
        // R4: stored upper field is always uniform
        a_r4_upper_uniform: assert property (@(posedge clk) disable iff (!rst_n)
          ((~|vals[gi][ACV_DATA_W-1:VA_BITS]) || (&vals[gi][ACV_DATA_W-1:VA_BITS])));
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_undef <= 1'b0;
      wr_busy  <= 1'b0;
    end else begin
      wr_undef <= wr_en & ~wr_impl;
      wr_busy  <= wr_en & wr_impl & ~trace_idle;
    end
  end

  always_comb begin
    rd_data  = '0;
    rd_undef = 1'b1;
    for (int i = 0; i < NUM_CMP; i++) begin
      if (rd_idx == ACV_IDX_W'(i)) begin
        rd_data  = vals[i];
        rd_undef = 1'b0;
      end
    end
  end

  // R5: the busy pulse lasts one cycle unless a new refused write follows
  a_r5_busy_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_busy && !(wr_en && wr_impl && !trace_idle)) |=> !wr_busy);

  // R1: undefined reads return zero
  a_r1_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_undef |-> (rd_data == '0));
endmodule

// File: rtl/acv_cmp_stage.sv
module acv_cmp_stage
  import acv_pkg::*;
#(
  parameter int NUM_CMP = 8
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic [NUM_CMP-1:0][ACV_DATA_W-1:0] vals,
  input  logic      s_valid,
  output logic      s_ready,
  input  acv_word_t s_addr,
  input  logic      s_narrow,
  output logic      m_valid,
  input  logic      m_ready,
  output acv_vec_t  m_match
);
  acv_word_t addr_ext;
  acv_vec_t  hits;
  logic      take;

  assign addr_ext = s_narrow ? {{(ACV_DATA_W-ACV_NARROW_W){1'b0}}, s_addr[ACV_NARROW_W-1:0]}
                             : s_addr;

  genvar gi;
  generate
    for (gi = 0; gi < ACV_SLOTS; gi++) begin : g_cmp
      if (gi < NUM_CMP) begin : g_on
        assign hits[gi] = enable & (vals[gi] == addr_ext);
      end else begin : g_off
        assign hits[gi] = 1'b0;
      end
    end
  endgenerate

  assign s_ready = ~m_valid | m_ready;
  assign take    = s_valid & s_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_match <= '0;
    end else if (take) begin
      m_valid <= 1'b1;
      m_match <= hits;
    end else if (m_ready) begin
      m_valid <= 1'b0;
    end
  end

  // R9: a stalled result holds
  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_match)));

  // R8: disabled samples yield an empty vector
  a_r8_disabled_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !enable) |=> (m_match == '0));

  // R7: an accepted sample always produces a result next cycle
  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> m_valid);

  // R6: a narrow sample never matches a value with high bits set
  a_r6_narrow_zext: assert property (@(posedge clk) disable iff (!rst_n)
    (take && s_narrow && (vals[0][ACV_DATA_W-1:ACV_NARROW_W] != '0)) |=> !m_match[0]);

  generate
    if (NUM_CMP < ACV_SLOTS) begin : g_unimpl_chk
      // R7: unimplemented bits stay clear
      a_r7_unimpl_clear: assert property (@(posedge clk) disable iff (!rst_n)
        m_match[ACV_SLOTS-1:NUM_CMP] == '0);
    end
  endgenerate
endmodule

// File: rtl/acv_bank.sv
module acv_bank
  import acv_pkg::*;
#(
  parameter int NUM_PAIRS = 4,
  parameter int VA_BITS   = 48
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        trace_idle,
  input  logic        wr_en,
  input  logic [3:0]  wr_idx,
  input  logic [63:0] wr_data,
  output logic        wr_undef,
  output logic        wr_busy,
  input  logic [3:0]  rd_idx,
  output logic [63:0] rd_data,
  output logic        rd_undef,
  input  logic        s_valid,
  output logic        s_ready,
  input  logic [63:0] s_addr,
  input  logic        s_narrow,
  output logic        m_valid,
  input  logic        m_ready,
  output logic [15:0] m_match
);
  localparam int NUM_CMP = 2 * NUM_PAIRS;

  logic [NUM_CMP-1:0][ACV_DATA_W-1:0] vals;

  initial begin
    a_param_range: assert (NUM_PAIRS >= 1 && NUM_PAIRS <= 8 && VA_BITS >= 32 && VA_BITS <= 64);
  end

  acv_value_bank #(.NUM_PAIRS(NUM_PAIRS), .VA_BITS(VA_BITS)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n),
    .trace_idle (trace_idle),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_data    (wr_data),
    .wr_undef   (wr_undef),
    .wr_busy    (wr_busy),
    .rd_idx     (rd_idx),
    .rd_data    (rd_data),
    .rd_undef   (rd_undef),
    .vals       (vals)
  );

  acv_cmp_stage #(.NUM_CMP(NUM_CMP)) u_cmp (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .vals     (vals),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_addr   (s_addr),
    .s_narrow (s_narrow),
    .m_valid  (m_valid),
    .m_ready  (m_ready),
    .m_match  (m_match)
  );

  // R11: result of a sample taken during a write uses the old values
  a_r11_old_value: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && enable && !s_narrow && (s_addr == vals[0])) |=> m_match[0]);
endmodule

// File: tb/acv_bank_bench.sv
module acv_bank_bench;
  localparam int CLK = 10;
  localparam int NP  = 4;
  localparam int P   = 48;
  localparam int NC  = 2 * NP;

  logic        clk = 1'b0;
  logic        rst_n, enable, trace_idle, wr_en, s_valid, s_narrow, m_ready;
  logic [3:0]  wr_idx, rd_idx;
  logic [63:0] wr_data, s_addr, rd_data;
  logic        wr_undef, wr_busy, rd_undef, s_ready, m_valid;
  logic [15:0] m_match;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK/2) clk = ~clk;

  acv_bank #(.NUM_PAIRS(NP), .VA_BITS(P)) u_acv_bank (
    .clk(clk), .rst_n(rst_n), .enable(enable), .trace_idle(trace_idle),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .wr_undef(wr_undef), .wr_busy(wr_busy),
    .rd_idx(rd_idx), .rd_data(rd_data), .rd_undef(rd_undef),
    .s_valid(s_valid), .s_ready(s_ready), .s_addr(s_addr), .s_narrow(s_narrow),
    .m_valid(m_valid), .m_ready(m_ready), .m_match(m_match)
  );

  // reference model
  logic [63:0] mval [16];
  logic        e_mv, e_undef, e_busy;
  logic [15:0] e_mm;

  function automatic bit is_impl(input logic [3:0] i);
    return int'(i) < NC;
  endfunction

  function automatic logic [63:0] clean(input logic [63:0] d);
    logic [63:0] hm;
    hm = ~((64'd1 << P) - 64'd1);
    if ((d & hm) == 64'd0 || (d & hm) == hm) return d;
    if (d[P-1]) return d | hm;
    return d & ~hm;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (mval[k]) mval[k] = 64'd0;
      e_mv = 0; e_mm = 0; e_undef = 0; e_busy = 0;
    end else begin
      logic [63:0] a;
      logic [15:0] v;
      bit rdy;
      rdy = !e_mv || m_ready;
      a = s_narrow ? {32'd0, s_addr[31:0]} : s_addr;
      v = 0;
      for (int k = 0; k < NC; k++) if (enable && mval[k] == a) v[k] = 1'b1;
      if (s_valid && rdy) begin e_mv = 1; e_mm = v; end
      else if (m_ready) e_mv = 0;
      e_undef = wr_en && !is_impl(wr_idx);
      e_busy  = wr_en && is_impl(wr_idx) && !trace_idle;
      if (wr_en && is_impl(wr_idx) && trace_idle) mval[wr_idx] = clean(wr_data);
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R9 m_valid", 64'(m_valid), 64'(e_mv));
      if (e_mv) chk("R7 m_match", 64'(m_match), 64'(e_mm));
      chk("R9 s_ready", 64'(s_ready), 64'(!e_mv || m_ready));
      chk("R1 wr_undef", 64'(wr_undef), 64'(e_undef));
      chk("R5 wr_busy", 64'(wr_busy), 64'(e_busy));
      chk("R1 rd_undef", 64'(rd_undef), 64'(!is_impl(rd_idx)));
      chk("R2 rd_data", rd_data, is_impl(rd_idx) ? mval[rd_idx] : 64'd0);
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [3:0] i, input logic [63:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic beat(input logic [63:0] a, input logic n);
    s_valid = 1; s_addr = a; s_narrow = n; step(); s_valid = 0;
  endtask

  initial begin
    #(CLK*100000);
    if (!done) begin
      done = 1; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; enable = 0; trace_idle = 1; wr_en = 0; wr_idx = 0; wr_data = 0;
    rd_idx = 0; s_valid = 0; s_addr = 0; s_narrow = 0; m_ready = 1;
    repeat (3) step();
    rst_n = 1;
    // R10 reset state
    for (int k = 0; k < NC; k++) begin rd_idx = 4'(k); #1 chk("R10 reset value", rd_data, 64'd0); end
    chk("R10 m_valid", 64'(m_valid), 64'd0);
    chk("R10 pulses", {62'd0, wr_undef, wr_busy}, 64'd0);
    enable = 1;
    // R3 uniform upper fields
    wr(4'd1, 64'hFFFF_8000_1234_5678); rd_idx = 1; #1 chk("R3 ones kept", rd_data, 64'hFFFF_8000_1234_5678);
    wr(4'd2, 64'h0000_0000_DEAD_BEEF); rd_idx = 2; #1 chk("R3 zeros kept", rd_data, 64'h0000_0000_DEAD_BEEF);
    // R4 mixed upper fields
    wr(4'd3, 64'h1234_7FFF_0000_0001); rd_idx = 3; #1 chk("R4 fill zero", rd_data, 64'h0000_7FFF_0000_0001);
    wr(4'd4, 64'h00F0_8000_0000_0002); rd_idx = 4; #1 chk("R4 fill one", rd_data, 64'hFFFF_8000_0000_0002);
    wr(4'd5, 64'h0000_0001_0000_00AA);
    // R1 unimplemented write and read
    wr(4'd12, 64'h55); #1 chk("R1 undef pulse", 64'(wr_undef), 64'd1);
    rd_idx = 12; #1 chk("R1 undef read", rd_data, 64'd0);
    // R5 busy write
    trace_idle = 0; wr(4'd2, 64'h99); #1 chk("R5 busy pulse", 64'(wr_busy), 64'd1);
    trace_idle = 1; rd_idx = 2; #1 chk("R5 not stored", rd_data, 64'h0000_0000_DEAD_BEEF);
    step(); chk("R5 pulse ends", 64'(wr_busy), 64'd0);
    // R6 narrow zero-extension
    beat(64'hABCD_0000_DEAD_BEEF, 1); chk("R6 narrow match", 64'(m_match[2]), 64'd1);
    beat(64'h0000_0000_0000_00AA, 1); chk("R6 high stored bits miss", 64'(m_match[5]), 64'd0);
    beat(64'h0000_0001_0000_00AA, 0); chk("R7 wide match", 64'(m_match), 64'h20);
    // R8 disabled
    enable = 0; beat(64'h0000_0000_DEAD_BEEF, 0); chk("R8 disabled", 64'(m_match), 64'd0);
    chk("R8 still valid", 64'(m_valid), 64'd1);
    enable = 1;
    // R11 same-cycle write
    wr_en = 1; wr_idx = 2; wr_data = 64'h77; beat(64'h0000_0000_DEAD_BEEF, 0); wr_en = 0;
    chk("R11 old value", 64'(m_match[2]), 64'd1);
    // R9 stall hold
    m_ready = 0; beat(64'h77, 0); chk("R9 hit held", 64'(m_match[2]), 64'd1);
    beat(64'h1, 0); chk("R9 stalled hold", 64'(m_match[2]), 64'd1);
    m_ready = 1; step();
    // random phase
    for (int c = 0; c < 2000; c++) begin
      int r;
      r = $urandom_range(0, 9);
      s_valid   = $urandom_range(0, 1);
      m_ready   = ($urandom_range(0, 3) != 0);
      enable    = ($urandom_range(0, 7) != 0);
      s_narrow  = $urandom_range(0, 1);
      s_addr    = (r < 6) ? mval[$urandom_range(0, NC-1)] ^ (s_narrow ? {32'($urandom), 32'd0} : 64'd0)
                          : {32'($urandom), 32'($urandom)};
      wr_en     = ($urandom_range(0, 5) == 0);
      wr_idx    = 4'($urandom_range(0, 15));
      trace_idle = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 3))
        0: wr_data = {32'($urandom), 32'($urandom)};
        1: wr_data = {32'd0, 32'($urandom)};
        2: wr_data = {16'hFFFF, 16'($urandom) | 16'h8000, 32'($urandom)};
        default: wr_data = {16'($urandom), 48'($urandom)};
      endcase
      rd_idx = 4'($urandom_range(0, 15));
      step();
    end
    wr_en = 0; s_valid = 0; m_ready = 1;
    repeat (3) step();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule